// File: doc/BRIEF.md
# Indirect DMA Channel Register Bank

This block holds the setup registers of a six-channel DMA controller and exposes them to a processor bus through only three bus addresses. A pointer register, written over the bus, selects one internal register by its sub-address. Two data windows then reach the selected register. One window advances the pointer by one after every read or write, so a run of accesses sweeps through consecutive registers. The other window leaves the pointer where it is, so one register can be polled or rewritten repeatedly.

Each channel owns five consecutive registers: source address, destination address, element count, sync-select/frame count and transfer mode. The bank ends with one page register that all channels share. Every register value is presented in parallel to the transfer engine. The engine, the global channel enable/priority register and interrupt logic are outside this block.

Top module: `dma_subbank_regs`

## Requirements
- R1: A bus write to the pointer address (parameter, default 55h) loads `wdata_i[4:0]` into the 5-bit pointer at the next edge. A read of that address returns the pointer zero-extended to 16 bits.
- R2: An access (read, write or both) to the stepping window (default 56h) reaches the register selected by the pointer. At the next clock edge the pointer then becomes pointer+1, modulo 32.
- R3: An access to the fixed window (default 57h) reaches the selected register and leaves the pointer unchanged.
- R4: Channel n (0..5) occupies sub-addresses 5n+k, with k=0 source, k=1 destination, k=2 element count, k=3 sync/frame, k=4 mode. The register at 5n+k drives bits [16n+15:16n] of `src_o`, `dst_o`, `cnt_o`, `sfc_o` or `mode_o` for k=0..4 respectively.
- R5: Sub-address 1Eh is the shared page register, and it drives `page_o`.
- R6: Sub-address 1Fh has no register: a write there changes no output, and a read returns 0. The stepping window still advances the pointer, and the pointer wraps from 1Fh to 00h.
- R7: The asynchronous active-low reset clears every bank register and the pointer to zero.
- R8: `rdata_o` is combinational, and it is valid in the same cycle as `re_i`. It is 0 when `re_i` is low or when the address is not one of the three block addresses.
- R9: A write to any other bus address changes neither the pointer nor any bank register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Bus address |
| wdata_i | input | 16 | Bus write data |
| we_i | input | 1 | Write enable |
| re_i | input | 1 | Read enable |
| rdata_o | output | 16 | Read data, combinational |
| src_o | output | 96 | Per-channel source address, 16 bits each |
| dst_o | output | 96 | Per-channel destination address |
| cnt_o | output | 96 | Per-channel element count |
| sfc_o | output | 96 | Per-channel sync select and frame count |
| mode_o | output | 96 | Per-channel transfer mode |
| page_o | output | 16 | Shared source program page |

## Verification
A wrong pointer value appears in the same cycle on any pointer read. After any data access, it also appears as data from the wrong register or as a write landing in the wrong channel field. A register that decodes the wrong sub-address or fails to hold shows on the parallel outputs one edge after the write. The bench therefore compares every parallel output and every read result against a behavioural model on every cycle. The stimulus includes full sweeps through the wrap at 1Fh, so a fault in the stepping logic is caught within one access of its cause.

// File: rtl/dma_sb_pkg.sv
package dma_sb_pkg;
  localparam int DATA_W      = 16;
  localparam int BUS_AW      = 8;
  localparam int NUM_CH      = 6;
  localparam int REGS_PER_CH = 5;

  typedef enum int {
    FLD_SRC  = 0,
    FLD_DST  = 1,
    FLD_CNT  = 2,
    FLD_SFC  = 3,
    FLD_MODE = 4
  } field_e;
endpackage

// File: rtl/dma_sb_decode.sv
module dma_sb_decode #(
  parameter int          BUS_AW   = 8,
  parameter logic [7:0]  PTR_ADDR = 8'h55,
  parameter logic [7:0]  INC_ADDR = 8'h56,
  parameter logic [7:0]  FIX_ADDR = 8'h57
) (
  input  logic [BUS_AW-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic              ptr_wr_o,
  output logic              ptr_rd_o,
  output logic              step_o,
  output logic              data_wr_o,
  output logic              data_rd_o
);
  logic hit_ptr, hit_inc, hit_fix;

  assign hit_ptr = (addr_i == BUS_AW'(PTR_ADDR));
  assign hit_inc = (addr_i == BUS_AW'(INC_ADDR));
  assign hit_fix = (addr_i == BUS_AW'(FIX_ADDR));

  assign ptr_wr_o  = we_i & hit_ptr;
  assign ptr_rd_o  = re_i & hit_ptr;
  assign step_o    = (we_i | re_i) & hit_inc;
  assign data_wr_o = we_i & (hit_inc | hit_fix);
  assign data_rd_o = re_i & (hit_inc | hit_fix);

  // R9: at most one target class is selected per cycle
  always_comb begin
    a_r9_single_target: assert ($countones({ptr_wr_o | ptr_rd_o, data_wr_o | data_rd_o}) <= 1)
      else $error("decode selects pointer and data window together");
  end
endmodule

// File: rtl/dma_sb_pointer.sv
module dma_sb_pointer #(
  parameter int SUB_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SUB_W-1:0] load_val_i,
  input  logic             step_i,
  output logic [SUB_W-1:0] ptr_o
);
  logic [SUB_W-1:0] ptr_q;

  // load wins over step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (load_i)  ptr_q <= load_val_i;
    else if (step_i)  ptr_q <= ptr_q + SUB_W'(1);
  end

  assign ptr_o = ptr_q;

  a_r1_ptr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ptr_o == $past(load_val_i));
  a_r2_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> ptr_o == SUB_W'($past(ptr_o) + SUB_W'(1)));
  a_r3_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(ptr_o));
endmodule

// File: rtl/dma_sb_regs.sv
module dma_sb_regs #(
  parameter int DATA_W = 16,
  parameter int SUB_W  = 5,
  parameter int N_REGS = 5,
  parameter int BASE   = 0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [SUB_W-1:0]         sub_i,
  input  logic                     wr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic [N_REGS*DATA_W-1:0] regs_o
);
  logic [N_REGS-1:0]              hit;
  logic [N_REGS-1:0][DATA_W-1:0]  rd_part;

  for (genvar k = 0; k < N_REGS; k++) begin : g_reg
    logic [DATA_W-1:0] q;

    assign hit[k] = (sub_i == SUB_W'(BASE + k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             q <= '0;
      else if (wr_i && hit[k]) q <= wdata_i;
    end

    assign regs_o[k*DATA_W +: DATA_W] = q;
    assign rd_part[k] = hit[k] ? q : '0;

    a_r4_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && hit[k]) |=> regs_o[k*DATA_W +: DATA_W] == $past(wdata_i));
    a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_i && hit[k]) |=> $stable(regs_o[k*DATA_W +: DATA_W]));
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < N_REGS; k++) rdata_o |= rd_part[k];
  end

  always_comb begin
    a_r4_onehot_hit: assert ($onehot0(hit)) else $error("overlapping sub-address decode");
  end
endmodule

// File: rtl/dma_subbank_regs.sv
module dma_subbank_regs
  import dma_sb_pkg::*;
#(
  parameter int          NUM_CH   = dma_sb_pkg::NUM_CH,
  parameter int          DW       = dma_sb_pkg::DATA_W,
  parameter int          AW       = dma_sb_pkg::BUS_AW,
  parameter logic [7:0]  PTR_ADDR = 8'h55,
  parameter logic [7:0]  INC_ADDR = 8'h56,
  parameter logic [7:0]  FIX_ADDR = 8'h57
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic                 we_i,
  input  logic                 re_i,
  output logic [DW-1:0]        rdata_o,
  output logic [NUM_CH*DW-1:0] src_o,
  output logic [NUM_CH*DW-1:0] dst_o,
  output logic [NUM_CH*DW-1:0] cnt_o,
  output logic [NUM_CH*DW-1:0] sfc_o,
  output logic [NUM_CH*DW-1:0] mode_o,
  output logic [DW-1:0]        page_o
);
  localparam int RPC      = REGS_PER_CH;
  localparam int N_USED   = NUM_CH * RPC + 1;
  localparam int SUB_W    = $clog2(N_USED);
  localparam int PAGE_SUB = NUM_CH * RPC;

  logic             ptr_wr, ptr_rd, step, data_wr, data_rd;
  logic [SUB_W-1:0] ptr;
  logic [NUM_CH-1:0][RPC*DW-1:0] ch_regs;
  logic [NUM_CH-1:0][DW-1:0]     ch_rd;
  logic [DW-1:0]                 page_rd;
  logic [DW-1:0]                 bank_rd;

  dma_sb_decode #(
    .BUS_AW(AW), .PTR_ADDR(PTR_ADDR), .INC_ADDR(INC_ADDR), .FIX_ADDR(FIX_ADDR)
  ) u_decode (
    .addr_i, .we_i, .re_i,
    .ptr_wr_o(ptr_wr), .ptr_rd_o(ptr_rd), .step_o(step),
    .data_wr_o(data_wr), .data_rd_o(data_rd)
  );

  dma_sb_pointer #(.SUB_W(SUB_W)) u_ptr (
    .clk_i, .rst_ni,
    .load_i(ptr_wr), .load_val_i(wdata_i[SUB_W-1:0]),
    .step_i(step), .ptr_o(ptr)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_sb_regs #(.DATA_W(DW), .SUB_W(SUB_W), .N_REGS(RPC), .BASE(c*RPC)) u_regs (
      .clk_i, .rst_ni, .sub_i(ptr), .wr_i(data_wr), .wdata_i,
      .rdata_o(ch_rd[c]), .regs_o(ch_regs[c])
    );
    assign src_o [c*DW +: DW] = ch_regs[c][FLD_SRC *DW +: DW];
    assign dst_o [c*DW +: DW] = ch_regs[c][FLD_DST *DW +: DW];
    assign cnt_o [c*DW +: DW] = ch_regs[c][FLD_CNT *DW +: DW];
    assign sfc_o [c*DW +: DW] = ch_regs[c][FLD_SFC *DW +: DW];
    assign mode_o[c*DW +: DW] = ch_regs[c][FLD_MODE*DW +: DW];
  end

  dma_sb_regs #(.DATA_W(DW), .SUB_W(SUB_W), .N_REGS(1), .BASE(PAGE_SUB)) u_page (
    .clk_i, .rst_ni, .sub_i(ptr), .wr_i(data_wr), .wdata_i,
    .rdata_o(page_rd), .regs_o(page_o)
  );

  always_comb begin
    bank_rd = page_rd;
    for (int c = 0; c < NUM_CH; c++) bank_rd |= ch_rd[c];
  end

  always_comb begin
    if (data_rd)     rdata_o = bank_rd;
    else if (ptr_rd) rdata_o = DW'(ptr);
    else             rdata_o = '0;
  end

  // R6: unbacked sub-addresses read as zero
  a_r6_hole_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && int'(ptr) >= N_USED) |-> rdata_o == '0);
  // R6: a write to an unbacked sub-address leaves the page register alone
  a_r6_hole_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && int'(ptr) >= N_USED) |=> $stable(page_o));
  // R8: idle read port
  a_r8_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |-> rdata_o == '0);
endmodule

// File: tb/dma_subbank_regs_tb_top.sv
module dma_subbank_regs_tb_top;
  localparam int NCH = 6;
  localparam int DW  = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [7:0]     addr = '0;
  logic [DW-1:0]  wdata = '0;
  logic           we = 1'b0, re = 1'b0;
  logic [DW-1:0]  rdata;
  logic [NCH*DW-1:0] src, dst, cnt, sfc, mode;
  logic [DW-1:0]  page;

  int checks = 0, failures = 0;
  bit done = 0;

  int model [32];
  int mptr;

  always #5 clk = ~clk;

  dma_subbank_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata),
    .src_o(src), .dst_o(dst), .cnt_o(cnt), .sfc_o(sfc), .mode_o(mode), .page_o(page)
  );

  function automatic void model_reset();
    foreach (model[i]) model[i] = 0;
    mptr = 0;
  endfunction

  function automatic int exp_rd(logic [7:0] a, bit r);
    if (!r) return 0;
    if (a == 8'h55) return mptr;
    if (a == 8'h56 || a == 8'h57) return (mptr == 31) ? 0 : model[mptr];
    return 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // R4/R5: compare every parallel output field against the model
  task automatic chk_outputs(string req);
    int act, exp;
    bit bad = 0;
    for (int c = 0; c < NCH; c++) begin
      for (int k = 0; k < 5; k++) begin
        case (k)
          0: act = int'(src [c*DW +: DW]);
          1: act = int'(dst [c*DW +: DW]);
          2: act = int'(cnt [c*DW +: DW]);
          3: act = int'(sfc [c*DW +: DW]);
          default: act = int'(mode[c*DW +: DW]);
        endcase
        exp = model[5*c+k];
        if (!bad && act != exp) begin
          bad = 1;
          chk($sformatf("%s R4 ch%0d fld%0d", req, c, k), act, exp);
        end
      end
    end
    if (!bad && int'(page) != model[30]) begin
      bad = 1;
      chk({req, " R5 page"}, int'(page), model[30]);
    end
    if (!bad) chk(req, 0, 0);
  endtask

  task automatic bus(string req, logic [7:0] a, bit w, bit r, logic [DW-1:0] d);
    @(negedge clk);
    chk_outputs(req);
    addr = a; we = w; re = r; wdata = d;
    #1;
    chk({req, " R8 rdata"}, int'(rdata), exp_rd(a, r));
    @(posedge clk);
    if (w && a == 8'h55) mptr = int'(d[4:0]);
    else begin
      if (w && (a == 8'h56 || a == 8'h57) && mptr != 31) model[mptr] = int'(d);
      if ((w || r) && a == 8'h56) mptr = (mptr + 1) % 32;
    end
    #1;
    addr = '0; we = 0; re = 0; wdata = '0;
  endtask

  initial begin
    #1ms;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    // R7: reset state
    chk_outputs("R7 reset");
    @(negedge clk); rst_n = 1'b1;
    bus("R7 ptr reset", 8'h55, 0, 1, '0);

    // R2/R6: sweep all 32 sub-addresses through stepping window, wrap 1F->00
    bus("R1 load", 8'h55, 1, 0, 16'hFFE0);
    for (int i = 0; i < 32; i++) bus("R2 sweep wr", 8'h56, 1, 0, DW'(16'h1000 + 16'(i) * 16'h0111));
    bus("R6 wrap", 8'h55, 0, 1, '0);
    for (int i = 0; i < 33; i++) bus("R2 sweep rd", 8'h56, 0, 1, '0);

    // R3: fixed window keeps pointer
    bus("R1 load 0A", 8'h55, 1, 0, 16'h000A);
    bus("R3 fix wr", 8'h57, 1, 0, 16'hBEEF);
    bus("R3 fix wr2", 8'h57, 1, 1, 16'hCAFE);
    bus("R3 fix rd", 8'h57, 0, 1, '0);
    bus("R3 ptr", 8'h55, 0, 1, '0);

    // R5: page register
    bus("R1 load 1E", 8'h55, 1, 0, 16'h001E);
    bus("R5 page wr", 8'h56, 1, 0, 16'h7A5C);
    bus("R6 hole wr", 8'h56, 1, 1, 16'hDEAD);
    bus("R6 ptr wrapped", 8'h55, 0, 1, '0);
    bus("R1 load 1F", 8'h55, 1, 0, 16'h001F);
    bus("R6 hole fix wr", 8'h57, 1, 0, 16'h5555);
    bus("R6 hole rd", 8'h57, 0, 1, '0);

    // R9: foreign addresses
    bus("R9 foreign wr", 8'h58, 1, 0, 16'h1234);
    bus("R9 foreign wr2", 8'h54, 1, 1, 16'h0003);
    bus("R8 foreign rd", 8'h00, 0, 1, '0);
    bus("R8 no re", 8'h57, 0, 0, '0);
    bus("R9 ptr", 8'h55, 0, 1, '0);

    // R4: per-channel fields via mixed ports
    for (int c = 0; c < NCH; c++) begin
      bus("R1 load ch", 8'h55, 1, 0, DW'(5*c));
      for (int k = 0; k < 5; k++) bus("R4 field", 8'h56, 1, 0, DW'(16'hA000 + 16'(c*16 + k)));
    end
    bus("R4 final", 8'h55, 0, 1, '0);

    // R7: asynchronous reset mid-run
    @(negedge clk); rst_n = 1'b0; #2;
    model_reset();
    chk_outputs("R7 async reset");
    @(negedge clk); rst_n = 1'b1;
    bus("R7 ptr after reset", 8'h55, 0, 1, '0);
    bus("R7 rd after reset", 8'h57, 0, 1, '0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule